// File: doc/BRIEF.md
# Chainable 13-Bit Interval Timer

This block is a programmable down-counting interval timer controlled through one 16-bit bus register. Software writes a 13-bit period value together with a clock source select, a run bit and a master enable. While running, the live counter steps down once per tick. When it reaches zero it raises a one-cycle interrupt pulse and reloads the programmed period, so the pulse repeats at a fixed rate.

Ticks come from one of two places. One is the system clock divided by two. The other is the rising edge of an external divider signal, normally the frame-sync output of a serial audio port. Choosing the second source chains the two dividers into one wider counter. Both sources become single-cycle enables inside the system clock domain, so the whole block runs on one clock.

Programming a zero period stops the interrupts after the current interval completes, which gives a single-pass mode. Clearing the master enable shuts the timer off for good: its register address then belongs to ordinary external use, and only a reset brings the timer back.

Top module: `cascade_dn_timer`

## Requirements
- R1: After reset the master enable is set, counting is off, the oscillator source is selected and the live count is zero, so `bus_free` is 0 and `irq` stays 0 until a write.
- R2: The register fields are: bits 12:0 the period value, bit 13 the source (0 = system clock / 2, 1 = rising edges of `chain_in`), bit 14 run (1 = counting), bit 15 master enable.
- R3: With the oscillator source, run set and a nonzero period N, the first `irq` pulse is seen 2N cycles after the clock edge that takes the write, and later pulses repeat every 2N cycles. Every accepted write restarts the divide-by-two phase.
- R4: `irq` is high for exactly one clock cycle per expiry.
- R5: A write with a nonzero period loads the live counter at once, which restarts the interval. A write with a zero period changes only the reload value: the running interval still ends with one pulse, and after that no further pulse occurs.
- R6: A live count of zero never produces an interrupt, so writing a zero period from the idle state keeps `irq` low.
- R7: While run is 0 the live count holds its value. Setting run again without a new nonzero period resumes counting from the held value.
- R8: A write with bit 15 = 0 clears the master enable. After that, all writes are ignored and no interrupt occurs until reset.
- R9: `bus_free` is 1 exactly when the master enable is cleared.
- R10: With the chained source, each rising edge of `chain_in` is one tick and system-clock ticks are ignored. The pulse for the Nth edge is visible in the cycle after the edge is sampled.
- R11: Reset restores the master enable after it has been cleared, and the timer works again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the timer register |
| wr_data | input | 16 | Write data (master, run, source, period) |
| chain_in | input | 1 | External divider output, counted on rising edges |
| irq | output | 1 | One-cycle interrupt pulse on expiry |
| bus_free | output | 1 | High once the timer has been permanently disabled |

## Verification
On every cycle, the embedded properties check these behaviours: the interrupt is a single-cycle pulse, a zero live count never fires, a halted counter holds its value, the master enable never returns once cleared, a disabled timer stays silent, and the chain edge detector never produces back-to-back ticks. Only the bench's scenarios can show the exact interval lengths. These include the 2N-cycle period swept over many period values up to the 13-bit maximum, the restart on a nonzero write, the final pulse of single-pass mode, the resume point after a halt, the count of chained edges, and recovery through reset.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Default geometry of the timer register
  localparam int TMR_CNT_W  = 13;
  localparam int TMR_DATA_W = 16;

  // Tick source selected by the source field
  typedef enum logic {
    SRC_OSC   = 1'b0,
    SRC_CHAIN = 1'b1
  } tmr_src_e;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = TMR_DATA_W,
  parameter int CNT_W  = TMR_CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              master,
  output logic              run,
  output tmr_src_e          src,
  output logic [CNT_W-1:0]  reload,
  output logic              wr_hit,
  output logic              load_live,
  output logic [CNT_W-1:0]  load_val
);

  localparam int SRC_BIT    = CNT_W;
  localparam int RUN_BIT    = CNT_W + 1;
  localparam int MASTER_BIT = CNT_W + 2;

  logic             new_master;
  logic [CNT_W-1:0] new_count;

  assign new_master = wr_data[MASTER_BIT];
  assign new_count  = wr_data[CNT_W-1:0];

  // A write is only taken while the timer still owns its address
  assign wr_hit    = wr_en & master;
  assign load_live = wr_hit & new_master & (new_count != '0);
  assign load_val  = new_count;

  always_ff @(posedge clk) begin
    if (rst) begin
      master <= 1'b1;
      run    <= 1'b0;
      src    <= SRC_OSC;
      reload <= '0;
    end else if (wr_hit) begin
      master <= new_master;
      if (new_master) begin
        run    <= wr_data[RUN_BIT];
        src    <= tmr_src_e'(wr_data[SRC_BIT]);
        reload <= new_count;
      end
    end
  end

  AST_MASTER_STICKY: assert property (@(posedge clk) disable iff (rst)
    !master |=> !master); // R8

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_pkg::*;
#(
  parameter int OSC_DIV = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     restart,
  input  tmr_src_e src,
  input  logic     chain_in,
  output logic     tick
);

  logic osc_tick;
  logic chain_q;
  logic chain_tick;

  generate
    if (OSC_DIV > 1) begin : g_div
      localparam int PW = $clog2(OSC_DIV);
      logic [PW-1:0] pre;

      always_ff @(posedge clk) begin
        if (rst || restart) begin
          pre <= '0;
        end else if (pre == PW'(OSC_DIV - 1)) begin
          pre <= '0;
        end else begin
          pre <= pre + 1'b1;
        end
      end

      assign osc_tick = (pre == PW'(OSC_DIV - 1));
    end else begin : g_nodiv
      assign osc_tick = 1'b1;
    end
  endgenerate

  // Rising-edge detect turns the external divider into one-cycle enables
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= 1'b0;
    end else begin
      chain_q <= chain_in;
    end
  end

  assign chain_tick = chain_in & ~chain_q;
  assign tick       = (src == SRC_CHAIN) ? chain_tick : osc_tick;

  AST_CHAIN_EDGE: assert property (@(posedge clk) disable iff (rst)
    chain_tick |=> !chain_tick); // R10

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = TMR_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master,
  input  logic             run,
  input  logic             tick,
  input  logic             wr_hit,
  input  logic             load_live,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic             irq
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             step;

  // A write owns its edge; counting resumes on the next tick
  assign step = master & run & tick & ~wr_hit & (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (load_live) begin
        cnt <= load_val;
      end else if (step) begin
        if (cnt == ONE) begin
          cnt <= reload;
          irq <= 1'b1;
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R4

  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |=> !irq); // R6

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (master && !run && !wr_hit) |=> $stable(cnt)); // R7

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    !master |=> !irq); // R8

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load_live |=> (cnt == $past(load_val))); // R5

endmodule

// File: rtl/cascade_dn_timer.sv
module cascade_dn_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W  = TMR_DATA_W,
  parameter int CNT_W   = TMR_CNT_W,
  parameter int OSC_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              chain_in,
  output logic              irq,
  output logic              bus_free
);

  logic             master;
  logic             run;
  tmr_src_e         src;
  logic [CNT_W-1:0] reload;
  logic             wr_hit;
  logic             load_live;
  logic [CNT_W-1:0] load_val;
  logic             tick;

  tmr_regs #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .master    (master),
    .run       (run),
    .src       (src),
    .reload    (reload),
    .wr_hit    (wr_hit),
    .load_live (load_live),
    .load_val  (load_val)
  );

  tmr_tick_gen #(
    .OSC_DIV (OSC_DIV)
  ) u_tick (
    .clk      (clk),
    .rst      (rst),
    .restart  (wr_hit),
    .src      (src),
    .chain_in (chain_in),
    .tick     (tick)
  );

  tmr_core #(
    .CNT_W (CNT_W)
  ) u_core (
    .clk       (clk),
    .rst       (rst),
    .master    (master),
    .run       (run),
    .tick      (tick),
    .wr_hit    (wr_hit),
    .load_live (load_live),
    .load_val  (load_val),
    .reload    (reload),
    .irq       (irq)
  );

  assign bus_free = ~master;

endmodule

// File: tb/tb_cascade_dn_timer.sv
`timescale 1ns/1ps
module tb_cascade_dn_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        chain_in = 1'b0;
  logic        irq;
  logic        bus_free;

  int n_chk  = 0;
  int n_fail = 0;

  cascade_dn_timer dut (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .chain_in (chain_in),
    .irq      (irq),
    .bus_free (bus_free)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Called just after a negedge; taken at the next posedge
  task automatic wr(input logic [15:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  // Returns the number of negedges until irq is seen, 0 if none
  task automatic measure(input int limit, output int k);
    k = 0;
    for (int j = 1; j <= limit; j++) begin
      @(negedge clk);
      if (irq) begin
        k = j;
        break;
      end
    end
  endtask

  initial begin
    #750000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int k;
    @(negedge clk);
    do_reset();

    // R1 reset state, R6 idle never fires
    chk("R1 irq after reset", irq, 0);
    chk("R1 bus_free after reset", bus_free, 0);
    measure(40, k);
    chk("R1 no irq without write", k, 0);
    wr(16'hC000);
    measure(60, k);
    chk("R6 zero period from idle", k, 0);

    // R3 sweep of the oscillator period, R2 field layout, R4 pulse width
    for (int n = 1; n <= 41; n++) begin
      int nv;
      nv = (n == 41) ? 8191 : n;
      do_reset();
      wr(16'hC000 | 16'(nv));
      measure(2 * nv + 4, k);
      chk("R3 R2 first interval", k, 2 * nv);
      measure(2 * nv + 4, k);
      chk("R3 R4 repeat interval", k, 2 * nv);
    end

    // R5 nonzero write restarts the interval
    do_reset();
    wr(16'hC00A);
    repeat (4) @(negedge clk);
    wr(16'hC003);
    measure(40, k);
    chk("R5 restart on nonzero write", k, 6);

    // R5 single pass: zero period keeps the running interval
    do_reset();
    wr(16'hC006);
    wr(16'hC000);
    measure(40, k);
    chk("R5 final pulse after zero write", k, 12);
    measure(60, k);
    chk("R5 no pulse after single pass", k, 0);

    // R7 halt and resume
    do_reset();
    wr(16'hC008);
    repeat (6) @(negedge clk);
    wr(16'h8000);
    measure(20, k);
    chk("R7 halted no irq", k, 0);
    wr(16'hC000);
    measure(30, k);
    chk("R7 resume from held count", k, 10);
    measure(60, k);
    chk("R7 R5 silent after resume pass", k, 0);

    // R10 chained source
    do_reset();
    wr(16'hE003);
    for (int p = 1; p <= 3; p++) begin
      chain_in = 1'b1;
      @(negedge clk);
      chk("R10 pulse on third chain edge", irq, (p == 3) ? 1 : 0);
      measure(4, k);
      chk("R10 high level adds no tick", k, 0);
      chain_in = 1'b0;
      measure(3, k);
      chk("R10 oscillator ignored", k, 0);
    end

    // R8 R9 sticky master disable, R11 reset recovery
    do_reset();
    wr(16'hC003);
    measure(20, k);
    chk("R8 counts before disable", k, 6);
    wr(16'h0000);
    chk("R9 bus_free after disable", bus_free, 1);
    measure(40, k);
    chk("R8 silent when disabled", k, 0);
    wr(16'hC003);
    chk("R8 re-enable write ignored", bus_free, 1);
    measure(40, k);
    chk("R8 no irq after ignored write", k, 0);
    do_reset();
    chk("R11 bus_free after reset", bus_free, 0);
    wr(16'hC003);
    measure(20, k);
    chk("R11 works again after reset", k, 6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule